// File: doc/BRIEF.md
# Aligned Multi-Channel PWM Generator

This block drives a set of pulse-width-modulated lines from one clock. Each line has its own period, pulse width and phase offset, and counts from zero at the instant the whole group was last started. Software (or any upstream logic) presents the next settings on staging inputs at any time. Those values stay inert until a load strobe requests a reconfiguration.

A reconfiguration is gentle. No line is cut short. Each line runs out its present period on the old settings, then parks low at its period end. The group restarts only when every line is parked. The restart happens on the next clock, or, when the sync-enable bit is set, on the next rising edge of an external sync input. At the restart, all lines copy the staged settings and begin counting from zero together. A line with zero offset therefore pulses in the very first cycle of the new period. A busy output covers the whole interval from the request to the restart.

Top module: `pwm_align_gen`

## Requirements
- R1: A running channel with period setting P repeats every P+1 cycles. Its counter starts at 0 in the cycle after a restart. Its line is high exactly when offset <= count < offset + width, so a width of 0 keeps it low.
- R2: A load strobe sampled while idle makes busy high from the next cycle. Busy stays high up to and including the restart edge, and is low after it.
- R3: After a load strobe, a channel keeps producing its old waveform until it reaches the last count of its period.
- R4: Once a channel reaches its period end during a pending reconfiguration, it holds its line low and does not count until the group restart. This applies to a zero-offset channel too.
- R5: With sync disabled, the restart takes place on the first clock edge after the last channel has parked. The new waveforms begin at count 0 in the cycle after that edge.
- R6: With sync enabled, the restart waits for a rising sync edge seen while all channels are parked. A sync input held high from earlier, or one that rose before all channels parked, causes no restart.
- R7: The staged settings have no effect on the lines until a restart copies them.
- R8: A load strobe that arrives while busy is already high is ignored and does not move the restart.
- R9: After reset, all lines are low, busy is low and every active setting is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shd_period_i | input | NCH*CW | Staged period per channel (P gives P+1 cycles), channel i at bits i*CW |
| shd_width_i | input | NCH*CW | Staged pulse width per channel |
| shd_offset_i | input | NCH*CW | Staged phase offset per channel |
| load_stb_i | input | 1 | Reconfiguration request, sampled at a clock edge |
| sync_i | input | 1 | External sync, rising-edge sensitive |
| sync_en_i | input | 1 | 1: the restart waits for a sync edge |
| pwm_o | output | NCH | Pulse lines |
| busy_o | output | 1 | Reconfiguration pending |

## Verification
A counter that skips its period end shows up at once: a line stays high or low one cycle too long, or keeps running while its neighbours park. Busy then stays high past the predicted restart cycle. A parked flag that clears early makes a line pulse during the wait. A bad restart shows as lines whose first new edge arrives one period late or misaligned with each other. All of these are visible within one period of the longest channel after the load strobe, so the bench compares every line and busy on every cycle from the strobe to two new periods past the restart.

// File: rtl/pwm_align_pkg.sv
package pwm_align_pkg;
  typedef enum logic [0:0] {
    ST_RUN  = 1'b0,
    ST_WAIT = 1'b1
  } algn_st_t;
endpackage

// File: rtl/pwm_sync_edge.sv
module pwm_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  output logic edge_o
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = sync_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign edge_o = sync_i & ~prev_q;

  // R6
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/pwm_align_ctrl.sv
module pwm_align_ctrl
  import pwm_align_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_stb_i,
  input  logic all_done_i,
  input  logic sync_en_i,
  input  logic sync_edge_i,
  output logic go_o,
  output logic drain_o,
  output logic busy_o
);
  algn_st_t state_q;
  algn_st_t state_d;
  logic     go_d;

  always_comb begin
    state_d = state_q;
    go_d    = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (load_stb_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (all_done_i && (!sync_en_i || sync_edge_i)) begin
          go_d    = 1'b1;
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign go_o    = go_d;
  assign drain_o = (state_q == ST_WAIT);
  assign busy_o  = (state_q == ST_WAIT);

  // R5
  go_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> all_done_i);
  // R6
  go_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_o && sync_en_i) |-> sync_edge_i);
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && load_stb_i) |=> busy_o);
  // R8
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !go_o) |=> busy_o);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          drain_i,
  input  logic [CW-1:0] shd_per_i,
  input  logic [CW-1:0] shd_wid_i,
  input  logic [CW-1:0] shd_off_i,
  output logic          pwm_o,
  output logic          done_o
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] ZERO = '0;

  logic [CW-1:0] per_q, wid_q, off_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hold_q, hold_d;
  logic          cfg_en;
  logic [CW:0]   stop_w;
  logic          in_win;

  assign cfg_en = go_i;

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    if (go_i) begin
      cnt_d  = ZERO;
      hold_d = 1'b0;
    end else if (!hold_q) begin
      if (cnt_q == per_q) begin
        if (drain_i) hold_d = 1'b1;
        else         cnt_d  = ZERO;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      wid_q <= '0;
      off_q <= '0;
    end else if (cfg_en) begin
      per_q <= shd_per_i;
      wid_q <= shd_wid_i;
      off_q <= shd_off_i;
    end
  end

  assign stop_w = {1'b0, off_q} + {1'b0, wid_q};
  assign in_win = (cnt_q >= off_q) && ({1'b0, cnt_q} < stop_w);
  assign pwm_o  = in_win && !hold_q;
  assign done_o = hold_q;

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |-> (cnt_q <= per_q));
  // R4
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !go_i) |=> (hold_q && $stable(cnt_q)));
  // R3
  late_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && !go_i && drain_i && (cnt_q != per_q)) |=> !hold_q);
  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> (cnt_q == ZERO && !hold_q));
endmodule

// File: rtl/pwm_align_gen.sv
module pwm_align_gen #(
  parameter int NCH = 3,
  parameter int CW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*CW-1:0] shd_period_i,
  input  logic [NCH*CW-1:0] shd_width_i,
  input  logic [NCH*CW-1:0] shd_offset_i,
  input  logic              load_stb_i,
  input  logic              sync_i,
  input  logic              sync_en_i,
  output logic [NCH-1:0]    pwm_o,
  output logic              busy_o
);
  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic           sync_edge_w;
  logic           go_w;
  logic           drain_w;
  logic [NCH-1:0] done_w;
  logic           all_done_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwm_sync_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sync_i (sync_i),
    .edge_o (sync_edge_w)
  );

  assign all_done_w = &done_w;

  pwm_align_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .load_stb_i  (load_stb_i),
    .all_done_i  (all_done_w),
    .sync_en_i   (sync_en_i),
    .sync_edge_i (sync_edge_w),
    .go_o        (go_w),
    .drain_o     (drain_w),
    .busy_o      (busy_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_chan #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .go_i      (go_w),
      .drain_i   (drain_w),
      .shd_per_i (shd_period_i[i*CW +: CW]),
      .shd_wid_i (shd_width_i[i*CW +: CW]),
      .shd_off_i (shd_offset_i[i*CW +: CW]),
      .pwm_o     (pwm_o[i]),
      .done_o    (done_w[i])
    );
  end

  // R4
  park_low_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && all_done_w) |-> (pwm_o == '0));
endmodule

// File: tb/pwm_align_gen_test.sv
module pwm_align_gen_test;
  localparam int NCH = 3;
  localparam int CW  = 8;

  typedef int cfg_t [NCH];
  typedef struct {
    int             n;
    logic [NCH-1:0] pwm;
    logic           busy;
    string          tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH*CW-1:0] shd_per = '0;
  logic [NCH*CW-1:0] shd_wid = '0;
  logic [NCH*CW-1:0] shd_off = '0;
  logic              load_stb = 1'b0;
  logic              sync_in = 1'b0;
  logic              sync_en = 1'b0;
  logic [NCH-1:0]    pwm;
  logic              busy;

  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;
  item_t q[$];
  item_t mit;
  cfg_t  cur_p = '{0, 0, 0};
  cfg_t  cur_w = '{0, 0, 0};
  cfg_t  cur_o = '{0, 0, 0};
  int    tr = 0;

  pwm_align_gen #(.NCH(NCH), .CW(CW)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .shd_period_i (shd_per),
    .shd_width_i  (shd_wid),
    .shd_offset_i (shd_off),
    .load_stb_i   (load_stb),
    .sync_i       (sync_in),
    .sync_en_i    (sync_en),
    .pwm_o        (pwm),
    .busy_o       (busy)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit win(int c, int o, int w);
    return (c >= o) && (c < o + w);
  endfunction

  task automatic check(string tag, logic [NCH-1:0] gp, logic [NCH-1:0] ep,
                       logic gb, logic eb);
    total++;
    if (gp !== ep || gb !== eb) begin
      bad++;
      $display("FAIL %s cycle %0d: pwm=%b busy=%b expected pwm=%b busy=%b",
               tag, cyc, gp, gb, ep, eb);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].n <= cyc) begin
      mit = q.pop_front();
      if (mit.n < cyc) begin
        total++;
        bad++;
        $display("FAIL %s: item for cycle %0d missed, expected pwm=%b", mit.tag, mit.n, mit.pwm);
      end else begin
        check(mit.tag, pwm, mit.pwm, busy, mit.busy);
      end
    end
  end

  task automatic apply_shadow(cfg_t np, cfg_t nw, cfg_t no);
    for (int i = 0; i < NCH; i++) begin
      shd_per[i*CW +: CW] = np[i][CW-1:0];
      shd_wid[i*CW +: CW] = nw[i][CW-1:0];
      shd_off[i*CW +: CW] = no[i][CW-1:0];
    end
  endtask

  // Free run with the current active settings; staged inputs must not matter (R7).
  task automatic idle_run(int k);
    int c0;
    item_t it;
    c0 = cyc;
    for (int n = c0 + 1; n <= c0 + k; n++) begin
      it.n = n;
      it.busy = 1'b0;
      it.tag = "R7 R1";
      for (int i = 0; i < NCH; i++)
        it.pwm[i] = win((n - tr) % (cur_p[i] + 1), cur_o[i], cur_w[i]);
      q.push_back(it);
    end
    while (cyc < c0 + k) @(negedge clk);
  endtask

  task automatic reconfig(cfg_t np, cfg_t nw, cfg_t no, bit use_sync, bit extra_stb);
    int s, g, maxh, maxp, lastn;
    int h[NCH];
    item_t it;
    apply_shadow(np, nw, no);
    sync_en = use_sync;
    @(negedge clk);
    s = cyc + 1;
    load_stb = 1'b1;
    maxh = 0;
    maxp = 0;
    for (int i = 0; i < NCH; i++) begin
      int n;
      n = s + 1;
      while (((n - tr) % (cur_p[i] + 1)) != 0) n++;
      h[i] = n;
      if (n > maxh) maxh = n;
      if (np[i] > maxp) maxp = np[i];
    end
    g = use_sync ? maxh + 4 : maxh + 1;
    lastn = g + 2 * (maxp + 1) + 2;
    for (int n = s; n <= lastn; n++) begin
      it.n = n;
      it.busy = (n < g);
      if (n < g) it.tag = use_sync ? "R2 R3 R4 R6" : (extra_stb ? "R2 R3 R4 R8" : "R2 R3 R4");
      else       it.tag = "R1 R5";
      for (int i = 0; i < NCH; i++) begin
        if (n < h[i])  it.pwm[i] = win((n - tr) % (cur_p[i] + 1), cur_o[i], cur_w[i]);
        else if (n < g) it.pwm[i] = 1'b0;
        else           it.pwm[i] = win((n - g) % (np[i] + 1), no[i], nw[i]);
      end
      q.push_back(it);
    end
    @(negedge clk);
    load_stb = 1'b0;
    if (use_sync) sync_in = 1'b1;   // early rise, before all channels parked (R6)
    while (cyc < lastn) begin
      @(negedge clk);
      load_stb = (extra_stb && cyc == s + 1);   // R8: strobe while busy
      if (use_sync) begin
        if (cyc == g - 3) sync_in = 1'b0;
        if (cyc == g - 1) sync_in = 1'b1;
      end
    end
    load_stb = 1'b0;
    sync_in = 1'b0;
    cur_p = np;
    cur_w = nw;
    cur_o = no;
    tr = g;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: reset state
    check("R9", pwm, '0, busy, 1'b0);
    // R7: staged values without a strobe leave lines low
    apply_shadow('{9, 9, 4}, '{3, 4, 0}, '{0, 5, 1});
    idle_run(6);
    // first configuration, zero width on channel 2 (R1)
    reconfig('{9, 9, 4}, '{3, 4, 0}, '{0, 5, 1}, 1'b0, 1'b0);
    idle_run(12);
    // R7: new staged values during run have no effect
    apply_shadow('{7, 11, 5}, '{2, 6, 5}, '{0, 3, 1});
    idle_run(7);
    // mid-period request, unequal periods, extra strobe while busy (R3 R4 R8)
    reconfig('{7, 11, 5}, '{2, 6, 5}, '{0, 3, 1}, 1'b0, 1'b1);
    idle_run(10);
    // sync-gated restart with early held-high sync (R6)
    reconfig('{5, 5, 9}, '{2, 3, 10}, '{0, 2, 0}, 1'b1, 1'b0);
    idle_run(10);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule